// File: doc/BRIEF.md
# Translation Cache Selective Invalidator

This block holds a small fully associative page translation cache and removes entries from it on command. Each entry stores a valid bit, a 32-bit virtual word, a 32-bit physical word and a privilege flag. Bits 31:12 of the virtual word are the page tag and bits 11:0 are control bits. A flush command names a privilege space, user or supervisor. It also chooses between every page in that space and the single page given by the address that comes with the command. The block latches the command and the address, then visits one entry per clock. It drops the valid bit of each live entry that meets the filter and leaves every other field of the entry as it was.

An external agent loads entries through a fill port and inspects them through a combinational read port. Software-visible state is limited to four flags. `busy` is high during a scan and `done` pulses when the scan ends. `err` pulses for an unknown command, and `overrun` is a sticky flag for a command issued during a scan.

Top module: `tci_top`

## Requirements
- R1: After a synchronous reset every entry reads back as all zeros, including its valid bit, and `busy`, `done`, `err` and `overrun` are low.
- R2: Command codes on the 4-bit `cmd_code` are 1 = user-all, 2 = user-page, 3 = supervisor-all and 4 = supervisor-page. The address is latched in the cycle the command is accepted, so later changes on `cmd_addr` do not affect the scan.
- R3: An all command invalidates every valid entry in the selected space, whatever its tag and the address.
- R4: A page command invalidates a valid entry in the selected space only when bits 31:12 of the latched address equal bits 31:12 of the entry's virtual word. Bits 11:0 of both are ignored.
- R5: User commands affect only entries with the privilege flag 0, and supervisor commands affect only entries with the flag 1.
- R6: A matching entry loses only its valid bit, and its virtual word, physical word and flag are unchanged. Entries that are already invalid and entries that do not match are not modified.
- R7: Any code other than 1 to 4 makes `err` high for exactly one cycle, the cycle after the strobe. It starts no scan and changes no entry.
- R8: An accepted command raises `busy` in the cycle after the strobe and holds it for exactly 56 cycles, one per entry. `done` is high for one cycle, in the first cycle with `busy` low again.
- R9: A strobe while `busy` is high is ignored. The scan in progress finishes with its own command, and `overrun` goes high and stays high until reset.
- R10: With `busy` low, `fill_en` writes the whole entry at `fill_idx` on the next edge. A fill while `busy` is high is ignored. `rd_idx` selects an entry that appears on the `rd_*` outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | Command strobe, one cycle |
| cmd_code | input | 4 | Flush command code |
| cmd_addr | input | 32 | Address compared by page commands |
| fill_en | input | 1 | Entry write enable |
| fill_idx | input | 6 | Entry index to write |
| fill_valid | input | 1 | Valid bit to write |
| fill_vword | input | 32 | Virtual word to write |
| fill_pword | input | 32 | Physical word to write |
| fill_supv | input | 1 | Privilege flag to write |
| rd_idx | input | 6 | Entry index to read |
| rd_valid | output | 1 | Valid bit of the selected entry |
| rd_vword | output | 32 | Virtual word of the selected entry |
| rd_pword | output | 32 | Physical word of the selected entry |
| rd_supv | output | 1 | Privilege flag of the selected entry |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at the end of a scan |
| err | output | 1 | One-cycle pulse for an unknown command |
| overrun | output | 1 | Sticky flag: command issued during a scan |

## Verification
A wrong scan index or a wrong filter decision shows up as a valid bit that is set or cleared when it should not be. The bench reads back every entry after each scan, so the fault is caught before the next command. A bad scan counter shows up immediately in the busy length, which is checked against 56 cycles, and in the position of the `done` pulse. If the latched address is corrupted, a page command clears the wrong page. If a field other than the valid bit is corrupted, the tag or physical word read back differs from the loaded value.

// File: rtl/tci_pkg.sv
package tci_pkg;

    localparam int TCI_AW       = 32;
    localparam int TCI_PAGE_LSB = 12;
    localparam int TCI_CODE_W   = 4;

    localparam logic [TCI_CODE_W-1:0] CMD_USER_ALL  = 4'h1;
    localparam logic [TCI_CODE_W-1:0] CMD_USER_PAGE = 4'h2;
    localparam logic [TCI_CODE_W-1:0] CMD_SUPV_ALL  = 4'h3;
    localparam logic [TCI_CODE_W-1:0] CMD_SUPV_PAGE = 4'h4;

    typedef struct packed {
        logic              valid;
        logic [TCI_AW-1:0] vword;
        logic [TCI_AW-1:0] pword;
        logic              supv;
    } entry_t;

    typedef struct packed {
        logic legal;
        logic supv;
        logic all;
    } flush_t;

    function automatic flush_t decode_cmd(input logic [TCI_CODE_W-1:0] code);
        flush_t f;
        f = '0;
        case (code)
            CMD_USER_ALL:  f = '{legal: 1'b1, supv: 1'b0, all: 1'b1};
            CMD_USER_PAGE: f = '{legal: 1'b1, supv: 1'b0, all: 1'b0};
            CMD_SUPV_ALL:  f = '{legal: 1'b1, supv: 1'b1, all: 1'b1};
            CMD_SUPV_PAGE: f = '{legal: 1'b1, supv: 1'b1, all: 1'b0};
            default:       f = '0;
        endcase
        return f;
    endfunction

    function automatic logic page_eq(input logic [TCI_AW-1:0] a,
                                     input logic [TCI_AW-1:0] b);
        return a[TCI_AW-1:TCI_PAGE_LSB] == b[TCI_AW-1:TCI_PAGE_LSB];
    endfunction

endpackage

// File: rtl/tci_sequencer.sv
module tci_sequencer
    import tci_pkg::*;
#(
    parameter int DEPTH = 56,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  flush_t            cmd,
    input  logic [TCI_AW-1:0] addr,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              ovr,
    output logic [IDX_W-1:0]  scan_idx,
    output logic              scan_supv,
    output logic              scan_all,
    output logic [TCI_AW-1:0] scan_addr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
            ovr       <= 1'b0;
            scan_idx  <= '0;
            scan_supv <= 1'b0;
            scan_all  <= 1'b0;
            scan_addr <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (busy) begin
                if (stb) ovr <= 1'b1;
                if (scan_idx == LAST) begin
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    scan_idx <= '0;
                end else begin
                    scan_idx <= scan_idx + 1'b1;
                end
            end else if (stb) begin
                if (cmd.legal) begin
                    busy      <= 1'b1;
                    scan_idx  <= '0;
                    scan_supv <= cmd.supv;
                    scan_all  <= cmd.all;
                    scan_addr <= addr;
                end else begin
                    err <= 1'b1;
                end
            end
        end
    end

    // R8: done only ends a scan
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
    // R8: busy continues until the last entry is visited
    a_r8_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && scan_idx != LAST) |=> busy);
    // R8: index stays inside the array
    a_r8_idx_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (scan_idx <= LAST));
    // R7: error never coincides with a scan
    a_r7_err_idle: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy);
    // R9: overrun is sticky
    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        ovr |=> ovr);

endmodule

// File: rtl/tci_store.sv
module tci_store
    import tci_pkg::*;
#(
    parameter int DEPTH = 56,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_en,
    input  logic [IDX_W-1:0]  scan_idx,
    input  logic              scan_supv,
    input  logic              scan_all,
    input  logic [TCI_AW-1:0] scan_addr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  entry_t            wr_entry,
    input  logic [IDX_W-1:0]  rd_idx,
    output entry_t            rd_entry
);

    entry_t             mem [DEPTH];
    logic [DEPTH-1:0]   valid_vec;
    entry_t             cur;
    logic               hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_vld
        assign valid_vec[g] = mem[g].valid;
    end

    always_comb begin
        cur = mem[scan_idx];
        hit = cur.valid && (cur.supv == scan_supv) &&
              (scan_all || page_eq(scan_addr, cur.vword));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (scan_en) begin
            if (hit) mem[scan_idx].valid <= 1'b0;
        end else if (wr_en && (int'(wr_idx) < DEPTH)) begin
            mem[wr_idx] <= wr_entry;
        end
    end

    always_comb begin
        if (int'(rd_idx) < DEPTH) rd_entry = mem[rd_idx];
        else                      rd_entry = '0;
    end

    // R10: with no scan and no fill the valid bits hold
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && !wr_en) |=> (valid_vec == $past(valid_vec)));
    // R6: a scan step touches at most one entry
    a_r6_one_step: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> ($countones(valid_vec ^ $past(valid_vec)) <= 1));
    // R6: a scan never sets a valid bit
    a_r6_no_revive: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> ((valid_vec & ~$past(valid_vec)) == '0));

endmodule

// File: rtl/tci_top.sv
module tci_top
    import tci_pkg::*;
#(
    parameter int DEPTH = 56,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_stb,
    input  logic [TCI_CODE_W-1:0] cmd_code,
    input  logic [TCI_AW-1:0]     cmd_addr,
    input  logic                  fill_en,
    input  logic [IDX_W-1:0]      fill_idx,
    input  logic                  fill_valid,
    input  logic [TCI_AW-1:0]     fill_vword,
    input  logic [TCI_AW-1:0]     fill_pword,
    input  logic                  fill_supv,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic                  rd_valid,
    output logic [TCI_AW-1:0]     rd_vword,
    output logic [TCI_AW-1:0]     rd_pword,
    output logic                  rd_supv,
    output logic                  busy,
    output logic                  done,
    output logic                  err,
    output logic                  overrun
);

    flush_t            cmd;
    logic [IDX_W-1:0]  scan_idx;
    logic              scan_supv;
    logic              scan_all;
    logic [TCI_AW-1:0] scan_addr;
    entry_t            wr_entry;
    entry_t            rd_entry;

    assign cmd      = decode_cmd(cmd_code);
    assign wr_entry = '{valid: fill_valid, vword: fill_vword,
                        pword: fill_pword, supv: fill_supv};

    tci_sequencer #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .stb       (cmd_stb),
        .cmd       (cmd),
        .addr      (cmd_addr),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .ovr       (overrun),
        .scan_idx  (scan_idx),
        .scan_supv (scan_supv),
        .scan_all  (scan_all),
        .scan_addr (scan_addr)
    );

    tci_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .scan_en   (busy),
        .scan_idx  (scan_idx),
        .scan_supv (scan_supv),
        .scan_all  (scan_all),
        .scan_addr (scan_addr),
        .wr_en     (fill_en && !busy),
        .wr_idx    (fill_idx),
        .wr_entry  (wr_entry),
        .rd_idx    (rd_idx),
        .rd_entry  (rd_entry)
    );

    assign rd_valid = rd_entry.valid;
    assign rd_vword = rd_entry.vword;
    assign rd_pword = rd_entry.pword;
    assign rd_supv  = rd_entry.supv;

endmodule

// File: tb/sim_tci_top.sv
module sim_tci_top;

    localparam int DEPTH = 56;

    typedef struct packed {
        logic        valid;
        logic [31:0] vword;
        logic [31:0] pword;
        logic        supv;
    } ment_t;

    typedef struct {
        int    idx;
        ment_t exp;
        string req;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_stb = 1'b0;
    logic [3:0]  cmd_code = '0;
    logic [31:0] cmd_addr = '0;
    logic        fill_en = 1'b0;
    logic [5:0]  fill_idx = '0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_vword = '0;
    logic [31:0] fill_pword = '0;
    logic        fill_supv = 1'b0;
    logic [5:0]  rd_idx = '0;
    logic        rd_valid, rd_supv, busy, done, err, overrun;
    logic [31:0] rd_vword, rd_pword;

    int checks = 0;
    int errors = 0;
    int pushed = 0;
    int popped = 0;
    ment_t model [DEPTH];
    sb_item_t sb_q [$];

    always #4 clk = ~clk;

    tci_top u0 (
        .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .fill_en(fill_en), .fill_idx(fill_idx),
        .fill_valid(fill_valid), .fill_vword(fill_vword),
        .fill_pword(fill_pword), .fill_supv(fill_supv), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_vword(rd_vword), .rd_pword(rd_pword),
        .rd_supv(rd_supv), .busy(busy), .done(done), .err(err),
        .overrun(overrun)
    );

    task automatic check(input string req, input logic [65:0] act,
                         input logic [65:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected entries and compares against the read port
    initial begin
        forever begin
            sb_item_t it;
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            @(negedge clk);
            rd_idx = 6'(it.idx);
            #1;
            check(it.req, {rd_valid, rd_vword, rd_pword, rd_supv}, it.exp);
            popped++;
        end
    end

    task automatic verify_all(input string req);
        for (int i = 0; i < DEPTH; i++) begin
            sb_item_t it;
            it.idx = i;
            it.exp = model[i];
            it.req = req;
            sb_q.push_back(it);
            pushed++;
        end
        wait (popped == pushed);
    endtask

    task automatic fill_one(input int i, input ment_t e, input bit upd);
        @(negedge clk);
        fill_en = 1'b1; fill_idx = 6'(i);
        fill_valid = e.valid; fill_vword = e.vword;
        fill_pword = e.pword; fill_supv = e.supv;
        @(negedge clk);
        fill_en = 1'b0;
        if (upd) model[i] = e;
    endtask

    function automatic ment_t pattern(input int i, input int seed);
        ment_t e;
        e.valid = ((i + seed) % 7) != 3;
        e.supv  = ((i / 2) % 2) == 1;
        e.vword = {20'h12340 + 20'(i % 5), 12'((i * 37 + seed) & 12'hfff)};
        e.pword = 32'hA000_0000 + 32'(i) * 32'h1111 + 32'(seed);
        return e;
    endfunction

    task automatic fill_all(input int seed);
        for (int i = 0; i < DEPTH; i++) fill_one(i, pattern(i, seed), 1'b1);
    endtask

    function automatic void apply(input logic [3:0] code, input logic [31:0] a);
        bit sp, al;
        sp = (code == 4'h3) || (code == 4'h4);
        al = (code == 4'h1) || (code == 4'h3);
        if (code < 4'h1 || code > 4'h4) return;
        for (int i = 0; i < DEPTH; i++)
            if (model[i].valid && model[i].supv == sp &&
                (al || model[i].vword[31:12] == a[31:12]))
                model[i].valid = 1'b0;
    endfunction

    // strobe, then count busy cycles and check the done pulse
    task automatic run_cmd(input logic [3:0] code, input logic [31:0] a,
                           input string req);
        int n;
        @(negedge clk);
        cmd_stb = 1'b1; cmd_code = code; cmd_addr = a;
        @(negedge clk);
        cmd_stb = 1'b0; cmd_addr = ~a;
        n = 0;
        while (busy && n < 1000) begin
            check({req, " R8 done low during scan"}, 66'(done), 66'(0));
            n++;
            @(negedge clk);
        end
        check({req, " R8 busy length"}, 66'(n), 66'(56));
        check({req, " R8 done pulse"}, 66'(done), 66'(1));
        @(negedge clk);
        check({req, " R8 done single"}, 66'(done), 66'(0));
        apply(code, a);
    endtask

    task automatic bad_cmd(input logic [3:0] code);
        @(negedge clk);
        cmd_stb = 1'b1; cmd_code = code; cmd_addr = 32'h1234_2000;
        @(negedge clk);
        cmd_stb = 1'b0;
        check("R7 err pulse", 66'({err, busy}), 66'(2'b10));
        @(negedge clk);
        check("R7 err single", 66'({err, busy, done}), 66'(0));
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 flags after reset", 66'({busy, done, err, overrun}), 66'(0));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        verify_all("R1 entry after reset");

        // R10 fill and read back
        fill_all(0);
        verify_all("R10 fill readback");

        // R4/R5/R6 user page flush, low address bits differ from tags
        run_cmd(4'h2, {20'h12342, 12'hABC}, "R2");
        verify_all("R4 R5 R6 user page");

        // supervisor page flush
        run_cmd(4'h4, {20'h12341, 12'h000}, "R2");
        verify_all("R4 R5 supervisor page");

        // R7 unknown codes change nothing
        bad_cmd(4'h9);
        bad_cmd(4'h0);
        verify_all("R7 no entry change");

        // R9 overrun and R10 fill ignored while busy, R3 user all
        @(negedge clk);
        cmd_stb = 1'b1; cmd_code = 4'h1; cmd_addr = 32'hDEAD_BEEF;
        @(negedge clk);
        cmd_stb = 1'b0;
        repeat (5) @(negedge clk);
        cmd_stb = 1'b1; cmd_code = 4'h3;
        @(negedge clk);
        cmd_stb = 1'b0;
        check("R9 overrun set", 66'(overrun), 66'(1));
        fill_one(5, pattern(5, 99), 1'b0);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        check("R9 first scan finished", 66'(done), 66'(1));
        @(negedge clk);
        check("R9 no second scan", 66'(busy), 66'(0));
        apply(4'h1, 32'hDEAD_BEEF);
        verify_all("R3 R9 R10 user all, busy fill ignored");

        // R3 supervisor all after refill, overrun still sticky
        fill_all(2);
        run_cmd(4'h3, 32'h0, "R2");
        verify_all("R3 R5 supervisor all");
        check("R9 overrun sticky", 66'(overrun), 66'(1));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule